// File: doc/BRIEF.md
# Static Memory Bank Sequencer

This block turns single requests from an on-chip requester into cycles on an external asynchronous static memory bus. The bus has four active-low chip selects and an address bus. Data travels on separate driven and sampled halves of a 16-bit data path, with an enable for the driven half. Each bank has its own configuration. A per-bank mode nibble selects 8-bit or 16-bit data and whether byte-lane strobes follow the request's byte mask. A per-bank timing word sets the setup, strobe and hold lengths in clock cycles, and can enable a four-beat page read.

A request is accepted while `req_ready` is high and `req_valid` is high. The sequencer then walks the phases in this order: address setup, chip-select setup, strobe (read or write), the extra page beats for page reads, chip-select hold and address hold. A phase whose length field is zero takes no cycles. Each completed data beat produces a one-cycle `rsp_valid` pulse. For reads, the sampled data appears on `rsp_rdata` during that pulse. Configuration is written through a simple write-only register port and is copied into the transaction when the request is accepted.

Top module: `smem_bank_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, all chip selects are 1, both strobes are 1 and the data path is not driven. All configuration clears to zero, which means 8-bit data, no page mode and every timing field 0.
- R2: Byte offset 0x0 is the mode word. Bank b owns bits [4b+3:4b]: bit 0 set means 16-bit data, bit 3 set means byte-lane strobes follow the request mask, and bits 1 and 2 are stored without effect. Byte offset 0x4+4b is the timing word of bank b: page enable [0], extra-beat length [7:4], address hold [11:8], chip-select hold [15:12], strobe length [20:16], chip-select setup [27:24] and address setup [31:28].
- R3: A read runs through the following phases, all counted in clock cycles. The address is presented with chip selects high for the address-setup count. The bank's chip select is then low for the chip-select-setup count. `mem_oen` is low for strobe length + 1 cycles. The chip select stays low for the chip-select-hold count after `mem_oen` rises. The address is kept for the address-hold count after the chip select rises. A zero count removes its phase, and the address bus reads 0 while idle.
- R4: A write has the same phases with `mem_wen` in place of `mem_oen`. `mem_dq_oe` is 1 exactly while the chip select is low.
- R5: A read on a bank with page mode enabled produces four beats. Beats 2 to 4 each last max(extra-beat length, 1) cycles. The beat address is the request address plus beat index × bytes per beat (1 or 2). The hold phases keep the last beat's address.
- R6: Data is sampled on the last cycle of each beat. `rsp_valid` is high for exactly the next cycle, once per beat for both reads and writes, and `rsp_rdata` carries the sampled read data in that cycle.
- R7: In 8-bit mode, `mem_ben` = 2'b10 (only lane 0 active, active low) while the chip select is low. Read data is {8'h00, lane 0} and the driven write data is {8'h00, write data[7:0]}.
- R8: In 16-bit mode, `mem_ben` is the inverse of `req_be` when the bank's byte-lane bit is set, and 2'b00 otherwise. `mem_ben` is 2'b11 whenever the chip selects are high.
- R9: Timing and mode are captured at acceptance. Configuration writes during a transaction change only later transactions.
- R10: `req_ready` is 1 only while no transaction is in progress. At most one chip select is low at a time, and the two strobes are never low together.
- R11: Page mode has no effect on writes, which always produce a single beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_bank | input | BANK_W | Target bank |
| req_addr | input | ADDR_W | Byte address within bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, active high |
| rsp_valid | output | 1 | One-cycle pulse per finished beat |
| rsp_rdata | output | 16 | Read data of the finished beat |
| mem_addr | output | ADDR_W | External address |
| mem_csn | output | NBANK | Chip selects, active low |
| mem_oen | output | 1 | Output enable, active low |
| mem_wen | output | 1 | Write enable, active low |
| mem_ben | output | 2 | Byte lanes, active low |
| mem_dq_out | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data returned by memory |

## Verification
Pins follow a request from the first cycle after the accepting edge. The response pulse comes one cycle after the last cycle of a beat, and a configuration write is visible from the next accepted request. The bench expands every request into a per-cycle list of expected pin values using its own copy of the configuration. It samples every output at the falling edge, one entry per cycle, so each result is compared in the cycle it is due. The expansion places each response pulse on the entry after its beat ends, including a trailing idle cycle when no hold phase follows.

// File: rtl/smem_pkg.sv
package smem_pkg;

    localparam int DATA_W     = 16;
    localparam int PAGE_BEATS = 4;
    localparam int BEAT_W     = $clog2(PAGE_BEATS);
    localparam int CNT_W      = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ASU,
        PH_CSU,
        PH_ACC,
        PH_PAGE,
        PH_COH,
        PH_CAH
    } phase_e;

    typedef struct packed {
        logic byte_lanes;
        logic wait_en;
        logic addr_mode;
        logic wide;
    } bank_mode_t;

    typedef struct packed {
        logic [3:0]       acs;
        logic [3:0]       cos;
        logic [CNT_W-1:0] acc;
        logic [3:0]       coh;
        logic [3:0]       cah;
        logic [3:0]       acp;
    } bank_timing_t;

    function automatic logic [CNT_W-1:0] hold_len(input logic [3:0] n);
        return (n == 4'd0) ? '0 : CNT_W'(n) - CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] phase_len(input phase_e p, input bank_timing_t t);
        logic [CNT_W-1:0] r;
        case (p)
            PH_ASU:  r = hold_len(t.acs);
            PH_CSU:  r = hold_len(t.cos);
            PH_ACC:  r = t.acc;
            PH_PAGE: r = hold_len(t.acp);
            PH_COH:  r = hold_len(t.coh);
            PH_CAH:  r = hold_len(t.cah);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic phase_e after_addr(input logic [3:0] cos);
        return (cos != 4'd0) ? PH_CSU : PH_ACC;
    endfunction

    function automatic phase_e tail_phase(input logic [3:0] coh, input logic [3:0] cah);
        if (coh != 4'd0) return PH_COH;
        if (cah != 4'd0) return PH_CAH;
        return PH_IDLE;
    endfunction

endpackage

// File: rtl/smem_cfg_regs.sv
module smem_cfg_regs
    import smem_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int CFG_AW = 5
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [CFG_AW-1:0]              addr,
    input  logic [31:0]                    wdata,
    output bank_mode_t   [NBANK-1:0]       mode_o,
    output bank_timing_t [NBANK-1:0]       timing_o,
    output logic         [NBANK-1:0]       page_o
);

    logic wdata_unused;
    assign wdata_unused = ^wdata[23:21];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [CFG_AW-1:0] TIM_OFS = CFG_AW'(4 * (b + 1));

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_o[b] <= '0;
            end else if (we && addr == '0) begin
                mode_o[b] <= bank_mode_t'(wdata[4*b +: 4]);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                timing_o[b] <= '0;
                page_o[b]   <= 1'b0;
            end else if (we && addr == TIM_OFS) begin
                timing_o[b].acs <= wdata[31:28];
                timing_o[b].cos <= wdata[27:24];
                timing_o[b].acc <= wdata[20:16];
                timing_o[b].coh <= wdata[15:12];
                timing_o[b].cah <= wdata[11:8];
                timing_o[b].acp <= wdata[7:4];
                page_o[b]       <= wdata[0];
            end
        end
    end

endmodule

// File: rtl/smem_seq.sv
module smem_seq
    import smem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bank_timing_t      t_in,
    input  logic              page_in,
    input  logic              wr_in,
    output phase_e            ph_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              beat_end_o
);

    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(PAGE_BEATS - 1);

    phase_e            ph, nph;
    logic [CNT_W-1:0]  cnt, ncnt;
    logic [BEAT_W-1:0] beat, nbeat;
    logic              burst, nburst;
    logic              reload;
    bank_timing_t      tq, tsrc;

    always_comb begin
        nph    = ph;
        ncnt   = cnt;
        nbeat  = beat;
        nburst = burst;
        tsrc   = tq;
        reload = 1'b0;
        if (ph == PH_IDLE) begin
            if (start) begin
                tsrc   = t_in;
                nburst = page_in && !wr_in;
                nbeat  = '0;
                reload = 1'b1;
                nph    = (t_in.acs != 4'd0) ? PH_ASU : after_addr(t_in.cos);
            end
        end else if (cnt != '0) begin
            ncnt = cnt - CNT_W'(1);
        end else begin
            reload = 1'b1;
            case (ph)
                PH_ASU: nph = after_addr(tq.cos);
                PH_CSU: nph = PH_ACC;
                PH_ACC: begin
                    if (burst) begin
                        nph   = PH_PAGE;
                        nbeat = BEAT_W'(1);
                    end else begin
                        nph = tail_phase(tq.coh, tq.cah);
                    end
                end
                PH_PAGE: begin
                    if (beat == LAST_BEAT) begin
                        nph = tail_phase(tq.coh, tq.cah);
                    end else begin
                        nph   = PH_PAGE;
                        nbeat = beat + BEAT_W'(1);
                    end
                end
                PH_COH:  nph = (tq.cah != 4'd0) ? PH_CAH : PH_IDLE;
                default: nph = PH_IDLE;
            endcase
        end
        if (reload) begin
            ncnt = phase_len(nph, tsrc);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            beat  <= '0;
            burst <= 1'b0;
            tq    <= '0;
        end else begin
            ph    <= nph;
            cnt   <= ncnt;
            beat  <= nbeat;
            burst <= nburst;
            if (ph == PH_IDLE && start) begin
                tq <= t_in;
            end
        end
    end

    assign ph_o       = ph;
    assign beat_o     = beat;
    assign beat_end_o = (ph == PH_ACC || ph == PH_PAGE) && (cnt == '0);

endmodule

// File: rtl/smem_bank_ctrl.sv
module smem_bank_ctrl
    import smem_pkg::*;
#(
    parameter  int NBANK  = 4,
    parameter  int ADDR_W = 16,
    localparam int CFG_AW = $clog2(4 * (NBANK + 1)),
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NBANK-1:0]  mem_csn,
    output logic              mem_oen,
    output logic              mem_wen,
    output logic [1:0]        mem_ben,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    bank_mode_t   [NBANK-1:0] mode_all;
    bank_timing_t [NBANK-1:0] timing_all;
    logic         [NBANK-1:0] page_all;

    smem_cfg_regs #(
        .NBANK (NBANK),
        .CFG_AW(CFG_AW)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .mode_o  (mode_all),
        .timing_o(timing_all),
        .page_o  (page_all)
    );

    logic              accept;
    phase_e            ph;
    logic [BEAT_W-1:0] beat;
    logic              beat_end;

    assign req_ready = (ph == PH_IDLE);
    assign accept    = req_valid && req_ready;

    smem_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .t_in      (timing_all[req_bank]),
        .page_in   (page_all[req_bank]),
        .wr_in     (req_write),
        .ph_o      (ph),
        .beat_o    (beat),
        .beat_end_o(beat_end)
    );

    // transaction context, captured once at acceptance
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        be_q;
    bank_mode_t        mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q  <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            be_q    <= '0;
            mode_q  <= '0;
        end else if (accept) begin
            bank_q  <= req_bank;
            addr_q  <= req_addr;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            mode_q  <= mode_all[req_bank];
        end
    end

    logic mode_unused;
    assign mode_unused = mode_q.wait_en ^ mode_q.addr_mode;

    logic       cs_on, strobe;
    logic [1:0] lanes;

    assign cs_on  = (ph == PH_CSU) || (ph == PH_ACC) || (ph == PH_PAGE) || (ph == PH_COH);
    assign strobe = (ph == PH_ACC) || (ph == PH_PAGE);

    always_comb begin
        if (!mode_q.wide)          lanes = 2'b10;
        else if (mode_q.byte_lanes) lanes = ~be_q;
        else                       lanes = 2'b00;
    end

    assign mem_csn    = cs_on ? ~(NBANK'(1) << bank_q) : '1;
    assign mem_oen    = !(strobe && !wr_q);
    assign mem_wen    = !(strobe && wr_q);
    assign mem_ben    = cs_on ? lanes : 2'b11;
    assign mem_dq_oe  = cs_on && wr_q;
    assign mem_dq_out = mode_q.wide ? wdata_q : {8'h00, wdata_q[7:0]};
    assign mem_addr   = (ph == PH_IDLE) ? '0 : addr_q + (ADDR_W'(beat) << mode_q.wide);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= beat_end;
            if (beat_end && !wr_q) begin
                rsp_rdata <= mode_q.wide ? mem_dq_in : {8'h00, mem_dq_in[7:0]};
            end
        end
    end

endmodule

// File: rtl/smem_bank_ctrl_chk.sv
module smem_bank_ctrl_chk #(
    parameter int NBANK  = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NBANK-1:0]  mem_csn,
    input logic              mem_oen,
    input logic              mem_wen,
    input logic              mem_dq_oe
);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_csn)); // R10

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oen && !mem_wen)); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (&mem_csn && mem_oen && mem_wen && !mem_dq_oe)); // R10

    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
        (!mem_oen || !mem_wen) |-> (mem_csn != '1)); // R3

    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oen); // R4

    AST_WR_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_wen && $past(!mem_wen)) |-> $stable(mem_addr)); // R4

    AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!mem_oen || !mem_wen)); // R6

endmodule

bind smem_bank_ctrl smem_bank_ctrl_chk #(
    .NBANK (NBANK),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_addr (mem_addr),
    .mem_csn  (mem_csn),
    .mem_oen  (mem_oen),
    .mem_wen  (mem_wen),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/smem_bank_ctrl_bench.sv
module smem_bank_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [15:0] mem_addr;
    logic [3:0]  mem_csn;
    logic        mem_oen, mem_wen, mem_dq_oe;
    logic [1:0]  mem_ben;
    logic [15:0] mem_dq_out, mem_dq_in;

    always #5 clk = ~clk;

    function automatic logic [15:0] memfun(input logic [15:0] a);
        return {a[7:0] ^ 8'hA5, a[7:0] + 8'h3C};
    endfunction

    assign mem_dq_in = memfun(mem_addr);

    smem_bank_ctrl u_smem_bank_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_csn(mem_csn),
        .mem_oen(mem_oen), .mem_wen(mem_wen), .mem_ben(mem_ben), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    typedef struct packed {
        logic        rdy;
        logic [3:0]  csn;
        logic        oen;
        logic        wen;
        logic [1:0]  ben;
        logic [15:0] addr;
        logic        dqoe;
        logic [15:0] dqo;
        logic        bv;
        logic        rdchk;
        logic [15:0] rd;
    } exp_t;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    bit          chk_on = 0;
    string       tag = "R1";
    logic [31:0] bw_sh = '0;
    logic [31:0] tm_sh [4] = '{default: '0};
    bit          pend_bv = 0;
    bit          pend_rdchk = 0;
    logic [15:0] pend_rd = '0;

    function automatic exp_t mk(input logic rdy, input logic [3:0] csn, input logic oen,
                                input logic wen, input logic [1:0] ben, input logic [15:0] a,
                                input logic dqoe, input logic [15:0] dqo);
        exp_t e;
        e.rdy = rdy; e.csn = csn; e.oen = oen; e.wen = wen; e.ben = ben; e.addr = a;
        e.dqoe = dqoe; e.dqo = dqoe ? dqo : 16'h0;
        e.bv = 1'b0; e.rdchk = 1'b0; e.rd = 16'h0;
        return e;
    endfunction

    task automatic push(input exp_t e);
        exp_t x = e;
        if (pend_bv) begin
            x.bv = 1'b1; x.rdchk = pend_rdchk; x.rd = pend_rdchk ? pend_rd : 16'h0;
            pend_bv = 0;
        end
        q.push_back(x);
    endtask

    // behavioural expansion of one request into expected pin values per cycle
    task automatic expand(input int bank, input logic [15:0] a, input bit wr,
                          input logic [15:0] wd, input logic [1:0] be);
        logic [31:0] tw = tm_sh[bank];
        logic [3:0]  nib = bw_sh[4*bank +: 4];
        int acs = tw[31:28], cos = tw[27:24], acc = tw[20:16];
        int coh = tw[15:12], cah = tw[11:8], acp = tw[7:4];
        bit w16 = nib[0];
        logic [3:0]  csl = 4'hF & ~(4'b0001 << bank);
        logic [1:0]  bact = !w16 ? 2'b10 : (nib[3] ? ~be : 2'b00);
        logic [15:0] dv = w16 ? wd : {8'h00, wd[7:0]};
        int nbeats = (tw[0] && !wr) ? 4 : 1;
        int stp = w16 ? 2 : 1;
        logic [15:0] la = a + 16'((nbeats - 1) * stp);
        for (int i = 0; i < acs; i++) push(mk(0, 4'hF, 1, 1, 2'b11, a, 0, dv));
        for (int i = 0; i < cos; i++) push(mk(0, csl, 1, 1, bact, a, wr, dv));
        for (int b = 0; b < nbeats; b++) begin
            logic [15:0] ab = a + 16'(b * stp);
            logic [15:0] f = memfun(ab);
            int len = (b == 0) ? acc + 1 : ((acp == 0) ? 1 : acp);
            for (int i = 0; i < len; i++) push(mk(0, csl, wr, !wr, bact, ab, wr, dv));
            pend_bv = 1; pend_rdchk = !wr; pend_rd = w16 ? f : {8'h00, f[7:0]};
        end
        for (int i = 0; i < coh; i++) push(mk(0, csl, 1, 1, bact, la, wr, dv));
        for (int i = 0; i < cah; i++) push(mk(0, 4'hF, 1, 1, 2'b11, la, 0, dv));
        if (pend_bv) push(mk(1, 4'hF, 1, 1, 2'b11, 16'h0, 0, 16'h0));
    endtask

    task automatic check_cycle();
        exp_t e, act;
        e = (q.size() > 0) ? q.pop_front() : mk(1, 4'hF, 1, 1, 2'b11, 16'h0, 0, 16'h0);
        act.rdy = req_ready; act.csn = mem_csn; act.oen = mem_oen; act.wen = mem_wen;
        act.ben = mem_ben; act.addr = mem_addr; act.dqoe = mem_dq_oe;
        act.dqo = e.dqoe ? mem_dq_out : 16'h0;
        act.bv = rsp_valid; act.rdchk = e.rdchk; act.rd = e.rdchk ? rsp_rdata : 16'h0;
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, e);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (chk_on) check_cycle();
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        if (a == 5'h0) bw_sh = d; else tm_sh[(a >> 2) - 1] = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic issue_start(input int bank, input logic [15:0] a, input bit wr,
                               input logic [15:0] wd, input logic [1:0] be);
        expand(bank, a, wr, wd, be);
        req_valid = 1'b1; req_bank = 2'(bank); req_addr = a; req_write = wr;
        req_wdata = wd; req_be = be;
        step();
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) step();
        step();
    endtask

    task automatic txn(input int bank, input logic [15:0] a, input bit wr,
                       input logic [15:0] wd, input logic [1:0] be);
        issue_start(bank, a, wr, wd, be);
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk_on = 1;
        // R1: idle pins after reset, then a read with all-zero configuration
        tag = "R1"; step(); step();
        tag = "R1/R6"; txn(2, 16'h0040, 0, 16'h0, 2'b00);
        // R2 R3: bank 1 16-bit with lanes, separated phases
        tag = "R2/R3";
        cfg_write(5'h00, 32'h0000_1090);
        cfg_write(5'h08, 32'h2103_1200);
        txn(1, 16'h0102, 0, 16'h0, 2'b11);
        // R4 R8: write with byte mask
        tag = "R4/R8";
        txn(1, 16'h0104, 1, 16'hBEEF, 2'b01);
        txn(1, 16'h0106, 1, 16'h1357, 2'b10);
        // R7 R3: 8-bit bank 0, zero phases skipped
        tag = "R7/R3";
        cfg_write(5'h04, 32'h0200_0000);
        txn(0, 16'h0010, 1, 16'h1234, 2'b11);
        txn(0, 16'h0011, 0, 16'h0, 2'b11);
        // R5 R6: 16-bit page read, beats of 2 cycles
        tag = "R5/R6";
        cfg_write(5'h10, 32'h0101_2121);
        txn(3, 16'h0200, 0, 16'h0, 2'b11);
        tag = "R5";
        cfg_write(5'h10, 32'h0101_2101);
        txn(3, 16'h0300, 0, 16'h0, 2'b11);
        tag = "R5/R7";
        cfg_write(5'h0C, 32'h0001_0031);
        txn(2, 16'h0050, 0, 16'h0, 2'b00);
        // R11: page bit set, write is one beat
        tag = "R11";
        txn(3, 16'h0400, 1, 16'hCAFE, 2'b11);
        // R9: configuration changes during a transaction
        tag = "R9";
        issue_start(1, 16'h0120, 0, 16'h0, 2'b11);
        cfg_write(5'h08, 32'hFF1F_FFF1);
        cfg_write(5'h00, 32'h0000_1000);
        drain();
        txn(1, 16'h0130, 0, 16'h0, 2'b11);
        // R8: 16-bit without lane control drives both lanes
        tag = "R8";
        cfg_write(5'h08, 32'h0000_0000);
        cfg_write(5'h00, 32'h0000_1010);
        txn(1, 16'h0140, 1, 16'hA55A, 2'b01);
        // R3: long setup and hold with page read on 8-bit bank 0
        tag = "R3";
        cfg_write(5'h04, 32'h1109_1C91);
        txn(0, 16'h00F0, 0, 16'h0, 2'b11);
        // R10: consecutive requests only after return to idle
        tag = "R10";
        txn(0, 16'h0001, 1, 16'h0077, 2'b11);
        txn(2, 16'h0002, 1, 16'h0088, 2'b11);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule